// File: doc/BRIEF.md
# Host Byte Interface for a Display Controller

This block is the host-facing front end of a display controller. A host moves 8-bit items into it, either as two 4-bit nibbles on a strobed parallel bus or as eight bits on a clocked serial line. A level on a mode pin chooses between the two. A second level, sampled when the byte completes, tags each item as a command or as memory data. Each finished byte goes to a downstream decoder as a one-cycle pulse with its tag. The block takes no part in decoding or executing the byte.

The host can also read. The downstream logic presents the byte to be returned, and the block drives it back either a nibble at a time or one bit at a time on bit 3 of the nibble output. After each completed transfer an active-low busy flag is held for a fixed number of internal cycles. The flag is only driven while the chip is selected. In systems with several chips sharing the bus, chip addressing can be enabled. The first byte after each select then carries an address, which is compared with two strap inputs, and a chip whose straps differ stays silent.

The strobe, serial clock and chip-select inputs are brought into the internal clock domain by a two-stage synchronizer. All other host-side levels are treated as quasi-static.

Top module: `hci_host_if`

## Requirements
- R1: A completed write byte appears on `byte_data` with `byte_valid` high for exactly one cycle. `byte_is_cmd` equals the `cd_sel` level (1 = command, 0 = data) held at completion.
- R2: In parallel mode a byte is two nibbles on `nib_in`, each captured when `stb_n` rises. The first nibble is bits 7..4 and the second is bits 3..0.
- R3: In serial mode a byte is eight bits on `sdi`, each captured when `sck` rises, most significant bit first.
- R4: `par_sel` = 1 selects the parallel bus and `par_sel` = 0 selects the serial line. Edges on the unselected interface's strobe or clock are ignored.
- R5: `busy_n` goes low in the cycle a byte completes and stays low for BUSY_CYCLES (default 4) cycles. `busy_oe` is high only while the chip is selected, or while it is selected and still awaiting its address byte.
- R6: Strobe or clock edges that arrive while busy is asserted are ignored and do not advance byte assembly.
- R7: Raising `cs_n` discards any partly received nibble pair or serial bit count.
- R8: With `addr_en` = 1 at the moment of select, the first byte after select is an address and is never forwarded. If its bits 1..0 differ from `strap`, later bytes are dropped and `busy_oe` and `dout_oe` stay low. If they match, later bytes are accepted.
- R9: After reset the stored chip address is 00. With `addr_en` raised while already selected, the chip accepts bytes only when `strap` = 00.
- R10: A parallel read drives `rd_byte` bits 7..4 on `dout` first and bits 3..0 after the first strobe. `rd_ack` pulses for one cycle after the second strobe.
- R11: A serial read drives `dout[3]` with `rd_byte` bit 7 first, moving to the next lower bit on each `sck` rise. `rd_ack` pulses for one cycle after the eighth rise.
- R12: While `rst_n` is low, `byte_valid`, `rd_ack`, `busy_oe` and `dout_oe` are low and `busy_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_sel | input | 1 | 1 = parallel nibble bus, 0 = serial line |
| cs_n | input | 1 | Active-low chip select |
| cd_sel | input | 1 | 1 = command byte, 0 = data byte |
| host_rd | input | 1 | 1 = host reads, 0 = host writes |
| stb_n | input | 1 | Active-low parallel strobe, captured on its rising edge |
| nib_in | input | NIB_W | Parallel nibble input |
| sck | input | 1 | Serial clock, captured on its rising edge |
| sdi | input | 1 | Serial data input |
| addr_en | input | 1 | Enables chip addressing |
| strap | input | ADDR_W | Strapped chip address |
| rd_byte | input | BYTE_W | Byte to be returned to the host |
| byte_valid | output | 1 | One-cycle pulse for a forwarded write byte |
| byte_data | output | BYTE_W | Assembled byte |
| byte_is_cmd | output | 1 | Command/data tag of the byte |
| rd_ack | output | 1 | One-cycle pulse when a read byte is finished |
| dout | output | NIB_W | Read nibble; bit 3 carries the serial output |
| dout_oe | output | 1 | Drive enable for `dout` |
| busy_n | output | 1 | Active-low busy flag |
| busy_oe | output | 1 | Drive enable for `busy_n` |

## Verification
A `stb_n` or `sck` rise acts on the third internal clock edge after it. At that edge `byte_valid` or `rd_ack` rises for one cycle and `busy_n` falls for four cycles. The bench drives every input at a falling clock edge and holds strobes, clocks and data for at least three cycles. A monitor samples at each falling edge, so every pulse is seen exactly once and is matched against the queue of expected items. Busy width is counted at those same falling edges. Read nibbles and serial output bits are sampled only after the previous edge has settled.

// File: rtl/hci_pkg.sv
package hci_pkg;

  localparam int HCI_NIB_W  = 4;
  localparam int HCI_BYTE_W = 8;
  localparam int HCI_ADDR_W = 2;

  typedef enum logic {
    IF_SERIAL   = 1'b0,
    IF_PARALLEL = 1'b1
  } if_mode_e;

endpackage

// File: rtl/hci_sync.sv
module hci_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);

  logic [STAGES:0][WIDTH-1:0] stg_q;
  logic [STAGES:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {(STAGES+1){RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q      = stg_q[STAGES-1];
  assign q_prev = stg_q[STAGES];

endmodule

// File: rtl/hci_busy_timer.sv
module hci_busy_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = CNT_W'(CYCLES);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);

  // R5: a completed byte always raises busy on the next cycle
  p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R5: the hold counter never exceeds its configured length
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CYCLES));

endmodule

// File: rtl/hci_assembler.sv
module hci_assembler import hci_pkg::*; #(
  parameter int NIB_W  = HCI_NIB_W,
  parameter int BYTE_W = HCI_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              par_mode,
  input  logic              accept,
  input  logic              stb_rise,
  input  logic              sck_rise,
  input  logic [NIB_W-1:0]  nib_in,
  input  logic              sdi,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              fin,
  output logic [BYTE_W-1:0] byte_q,
  output logic [NIB_W-1:0]  dout
);

  localparam int NIBBLES = BYTE_W / NIB_W;
  localparam int POS_W   = $clog2(BYTE_W);
  localparam int NSEL_W  = (NIBBLES > 1) ? $clog2(NIBBLES) : 1;

  if_mode_e mode;
  assign mode = if_mode_e'(par_mode);

  logic [POS_W-1:0]  pos_q, pos_d;
  logic [BYTE_W-1:0] shift_q, shift_d, byte_d, shift_in;
  logic              step, last;

  // Step and byte-end detection.
  always_comb begin
    step = accept && cs_act &&
           ((mode == IF_PARALLEL) ? stb_rise : sck_rise);
    last = (mode == IF_PARALLEL) ? (pos_q == POS_W'(NIBBLES - 1))
                                 : (pos_q == POS_W'(BYTE_W - 1));
    if (mode == IF_PARALLEL) begin
      shift_in = {shift_q[BYTE_W-NIB_W-1:0], nib_in};
    end else begin
      shift_in = {shift_q[BYTE_W-2:0], sdi};
    end
  end

  assign fin = step && last;

  // Next-state logic.
  always_comb begin
    pos_d   = pos_q;
    shift_d = shift_q;
    byte_d  = byte_q;
    if (!cs_act) begin
      pos_d = '0;
    end else if (step) begin
      shift_d = shift_in;
      if (last) begin
        pos_d  = '0;
        byte_d = shift_in;
      end else begin
        pos_d = pos_q + POS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      shift_q <= '0;
      byte_q  <= '0;
    end else begin
      pos_q   <= pos_d;
      shift_q <= shift_d;
      byte_q  <= byte_d;
    end
  end

  // Read path: nibbles taken from the top down.
  logic [NIB_W-1:0] nib_arr [NIBBLES];
  for (genvar k = 0; k < NIBBLES; k++) begin : g_nib
    assign nib_arr[k] = rd_byte[BYTE_W-1-k*NIB_W -: NIB_W];
  end

  logic sdo;
  always_comb begin
    sdo = rd_byte[POS_W'(BYTE_W - 1) - pos_q];
    if (mode == IF_PARALLEL) begin
      dout = nib_arr[pos_q[NSEL_W-1:0]];
    end else begin
      dout = {sdo, {(NIB_W-1){1'b0}}};
    end
  end

  // R7: a deselect leaves no partial progress behind
  p_clear_on_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (pos_q == '0));

endmodule

// File: rtl/hci_host_if.sv
module hci_host_if import hci_pkg::*; #(
  parameter int NIB_W       = HCI_NIB_W,
  parameter int BYTE_W      = HCI_BYTE_W,
  parameter int ADDR_W      = HCI_ADDR_W,
  parameter int BUSY_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_sel,
  input  logic              cs_n,
  input  logic              cd_sel,
  input  logic              host_rd,
  input  logic              stb_n,
  input  logic [NIB_W-1:0]  nib_in,
  input  logic              sck,
  input  logic              sdi,
  input  logic              addr_en,
  input  logic [ADDR_W-1:0] strap,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_is_cmd,
  output logic              rd_ack,
  output logic [NIB_W-1:0]  dout,
  output logic              dout_oe,
  output logic              busy_n,
  output logic              busy_oe
);

  localparam int SYNC_W = 3;

  // Bring the host edges into the clock domain.
  logic [SYNC_W-1:0] raw_in, s_q, s_prev;
  assign raw_in = {sck, stb_n, cs_n};

  hci_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({SYNC_W{1'b1}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (s_q),
    .q_prev(s_prev)
  );

  logic cs_act, sel_edge, stb_rise, sck_rise;
  assign cs_act   = ~s_q[0];
  assign sel_edge = s_prev[0] & ~s_q[0];
  assign stb_rise = s_q[1] & ~s_prev[1];
  assign sck_rise = s_q[2] & ~s_prev[2];

  logic              busy, fin;
  logic [BYTE_W-1:0] asm_byte;
  logic [NIB_W-1:0]  asm_dout;

  hci_assembler #(
    .NIB_W (NIB_W),
    .BYTE_W(BYTE_W)
  ) u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_act  (cs_act),
    .par_mode(par_sel),
    .accept  (~busy),
    .stb_rise(stb_rise),
    .sck_rise(sck_rise),
    .nib_in  (nib_in),
    .sdi     (sdi),
    .rd_byte (rd_byte),
    .fin     (fin),
    .byte_q  (asm_byte),
    .dout    (asm_dout)
  );

  hci_busy_timer #(
    .CYCLES(BUSY_CYCLES)
  ) u_busy (
    .clk  (clk),
    .rst_n(rst_n),
    .start(fin),
    .busy (busy)
  );

  // Chip-address and result state.
  logic              pending_q, pending_d;
  logic              load_q, load_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              valid_q, valid_d;
  logic              ack_q, ack_d;
  logic              cmd_q, cmd_d;
  logic              need_addr, match, selected, live;

  always_comb begin
    need_addr = addr_en & pending_q;
    match     = (addr_q == strap);
    selected  = ~addr_en | match;
    live      = cs_act & selected & ~need_addr;
  end

  always_comb begin
    pending_d = pending_q;
    if (sel_edge) begin
      pending_d = addr_en;
    end else if (load_q) begin
      pending_d = 1'b0;
    end
    load_d  = fin & need_addr;
    addr_d  = load_q ? asm_byte[ADDR_W-1:0] : addr_q;
    valid_d = fin & live & ~host_rd;
    ack_d   = fin & live & host_rd;
    cmd_d   = fin ? cd_sel : cmd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      load_q    <= 1'b0;
      addr_q    <= '0;
      valid_q   <= 1'b0;
      ack_q     <= 1'b0;
      cmd_q     <= 1'b0;
    end else begin
      pending_q <= pending_d;
      load_q    <= load_d;
      addr_q    <= addr_d;
      valid_q   <= valid_d;
      ack_q     <= ack_d;
      cmd_q     <= cmd_d;
    end
  end

  assign byte_valid  = valid_q;
  assign byte_data   = asm_byte;
  assign byte_is_cmd = cmd_q;
  assign rd_ack      = ack_q;
  assign dout        = asm_dout;
  assign dout_oe     = live & host_rd;
  assign busy_n      = ~busy;
  assign busy_oe     = cs_act & (selected | need_addr);

  // R1: a write byte is announced for one cycle only
  p_valid_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R5: every forwarded byte is accompanied by busy
  p_busy_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> busy);

  // R6: no byte completes while the hold is running
  p_no_fin_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fin);

  // R10: write and read completions never coincide
  p_excl_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && rd_ack));

endmodule

// File: tb/hci_host_if_test.sv
module hci_host_if_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       par_sel, cs_n, cd_sel, host_rd, stb_n, sck, sdi, addr_en;
  logic [3:0] nib_in;
  logic [1:0] strap;
  logic [7:0] rd_byte;
  logic       byte_valid, byte_is_cmd, rd_ack, dout_oe, busy_n, busy_oe;
  logic [7:0] byte_data;
  logic [3:0] dout;

  always #5 clk = ~clk;

  hci_host_if uut (
    .clk(clk), .rst_n(rst_n), .par_sel(par_sel), .cs_n(cs_n), .cd_sel(cd_sel),
    .host_rd(host_rd), .stb_n(stb_n), .nib_in(nib_in), .sck(sck), .sdi(sdi),
    .addr_en(addr_en), .strap(strap), .rd_byte(rd_byte),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_is_cmd(byte_is_cmd),
    .rd_ack(rd_ack), .dout(dout), .dout_oe(dout_oe), .busy_n(busy_n),
    .busy_oe(busy_oe)
  );

  typedef struct {
    bit         is_read;
    bit         is_cmd;
    logic [7:0] data;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_item(bit rd, bit cmd, logic [7:0] d, string tag);
    exp_t e;
    e.is_read = rd; e.is_cmd = cmd; e.data = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor / scoreboard, plus busy-width counting.
  int busy_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (byte_valid || rd_ack) begin
        if (exp_q.size() == 0) begin
          check(0, "R8", "unexpected output event", {byte_valid, rd_ack}, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.is_read) begin
            check(rd_ack && !byte_valid, e.tag, "read ack", {byte_valid, rd_ack}, 1);
          end else begin
            check(byte_valid && !rd_ack, e.tag, "write pulse", {byte_valid, rd_ack}, 2);
            check(byte_data == e.data, e.tag, "byte data", byte_data, e.data);
            check(byte_is_cmd == e.is_cmd, "R1", "cmd tag", byte_is_cmd, e.is_cmd);
          end
        end
      end
      if (busy_oe && !busy_n) begin
        busy_cnt++;
      end else if (busy_oe && busy_n && busy_cnt != 0) begin
        check(busy_cnt == 4, "R5", "busy width", busy_cnt, 4);
        busy_cnt = 0;
      end else if (!busy_oe) begin
        busy_cnt = 0;
      end
    end
  end

  task automatic nib_pulse(logic [3:0] n);
    @(negedge clk); nib_in = n; stb_n = 1'b0;
    repeat (3) @(negedge clk);
    stb_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic ser_bit(logic b);
    @(negedge clk); sdi = b; sck = 1'b0;
    repeat (3) @(negedge clk);
    sck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle();
    repeat (10) @(negedge clk);
  endtask

  task automatic par_write(logic [7:0] b, bit cmd, bit fwd, string tag);
    if (fwd) expect_item(0, cmd, b, tag);
    cd_sel = cmd;
    nib_pulse(b[7:4]);
    nib_pulse(b[3:0]);
    wait_idle();
  endtask

  task automatic ser_write(logic [7:0] b, bit cmd, string tag);
    expect_item(0, cmd, b, tag);
    cd_sel = cmd;
    for (int i = 7; i >= 0; i--) ser_bit(b[i]);
    wait_idle();
  endtask

  task automatic select();
    @(negedge clk); cs_n = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic release_cs();
    @(negedge clk); cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got;
    rst_n = 1'b0; par_sel = 1'b1; cs_n = 1'b1; cd_sel = 1'b0; host_rd = 1'b0;
    stb_n = 1'b1; sck = 1'b1; sdi = 1'b0; addr_en = 1'b0; nib_in = '0;
    strap = 2'b00; rd_byte = '0;
    repeat (5) @(negedge clk);
    // R12: reset state
    check(!byte_valid && !rd_ack, "R12", "pulses in reset", {byte_valid, rd_ack}, 0);
    check(!busy_oe && !dout_oe && busy_n, "R12", "drive state in reset",
          {busy_oe, dout_oe, busy_n}, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1, R2: parallel writes with several patterns
    select();
    check(busy_oe && busy_n, "R5", "busy driven idle when selected", {busy_oe, busy_n}, 3);
    par_write(8'h3A, 1, 1, "R2");
    par_write(8'hC5, 0, 1, "R2");
    par_write(8'hFF, 1, 1, "R1");
    par_write(8'h00, 0, 1, "R1");

    // R4: serial clocks ignored in parallel mode
    for (int i = 0; i < 8; i++) ser_bit(1'b1);
    par_write(8'h5B, 0, 1, "R4");

    // R6: strobe glitch during busy is ignored
    expect_item(0, 1, 8'h81, "R6");
    cd_sel = 1'b1;
    nib_pulse(4'h8);
    @(negedge clk); nib_in = 4'h1; stb_n = 1'b0;
    repeat (3) @(negedge clk);
    stb_n = 1'b1;
    @(negedge clk); stb_n = 1'b0;
    @(negedge clk); stb_n = 1'b1;
    wait_idle();
    par_write(8'h6E, 0, 1, "R6");

    // R7: deselect drops a lone nibble
    nib_pulse(4'h9);
    release_cs();
    select();
    par_write(8'h47, 1, 1, "R7");

    // R3, R4: serial mode, strobes ignored
    release_cs();
    par_sel = 1'b0;
    select();
    nib_pulse(4'hE);
    nib_pulse(4'h2);
    ser_write(8'hB2, 1, "R3");
    ser_write(8'h5D, 0, "R4");

    // R11: serial read
    host_rd = 1'b1; rd_byte = 8'h3C;
    @(negedge clk);
    check(dout_oe, "R11", "dout driven", dout_oe, 1);
    expect_item(1, 0, 8'h00, "R11");
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sck = 1'b0;
      repeat (3) @(negedge clk);
      got[i] = dout[3];
      sck = 1'b1;
      repeat (3) @(negedge clk);
    end
    check(got == 8'h3C, "R11", "serial read byte", got, 8'h3C);
    wait_idle();

    // R10: parallel read
    release_cs();
    par_sel = 1'b1; rd_byte = 8'hA5;
    select();
    check(dout_oe && dout == 4'hA, "R10", "upper nibble", dout, 4'hA);
    nib_pulse(4'h0);
    check(dout == 4'h5, "R10", "lower nibble", dout, 4'h5);
    expect_item(1, 0, 8'h00, "R10");
    nib_pulse(4'h0);
    wait_idle();
    host_rd = 1'b0;

    // R9: stored address is 00 after reset
    addr_en = 1'b1; strap = 2'b00;
    par_write(8'h12, 0, 1, "R9");
    strap = 2'b01;
    @(negedge clk);
    check(!busy_oe, "R9", "busy released on strap mismatch", busy_oe, 0);
    par_write(8'h34, 0, 0, "R9");

    // R8: address byte compare
    release_cs();
    strap = 2'b10;
    select();
    par_write(8'h01, 0, 0, "R8");
    check(!busy_oe, "R8", "mismatch leaves busy undriven", busy_oe, 0);
    par_write(8'h55, 0, 0, "R8");
    host_rd = 1'b1;
    @(negedge clk);
    check(!dout_oe, "R8", "mismatch leaves dout undriven", dout_oe, 0);
    host_rd = 1'b0;
    release_cs();
    select();
    par_write(8'h02, 0, 0, "R8");
    check(busy_oe, "R8", "match drives busy", busy_oe, 1);
    par_write(8'h66, 1, 1, "R8");

    release_cs();
    check(exp_q.size() == 0, "R1", "missing outputs", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule